// File: doc/BRIEF.md
# Recirculating Systolic Row Sequencer

This block is the storage and sequencing fabric around one physical row of systolic cells used for matrix inversion. For an N×N problem the row holds one boundary cell (index 0) and 2N−1 internal cells (indices 1 to 2N−1). The cells sit outside this block. It sees their results and feeds their operands through ports. Every logical layer of the classic trapezoidal array is played on this one row. Each cell result drops into a register column beneath that cell and comes back out, 2(N−1) clocks later, as an operand of the cell one position to the right.

A counter schedule decides for every cell and every cycle three things. The first is whether the operand comes fresh from the matrix input or from the feedback path. The second is whether the cell triangulates or annuls. The third is whether its internal state is cleared. The schedule is produced once for cell 0. Each cell further right sees it one clock later than its left neighbour, which matches the diagonal wavefront of skewed input data. The schedule repeats every 2(N²−1) cycles and can be restarted synchronously.

Top module: `sysrow_seq`

## Requirements
- R1: For every cell k ≥ 1 whose select bit is 0, `cell_in` slice k equals `cell_res` slice k−1 exactly 2(N−1) clock edges earlier, and equals 0 for the first 2(N−1) edges after reset.
- R2: When a cell's select bit is 1, its `cell_in` slice equals its `mat_in` slice in the same cycle. When cell 0's select bit is 0, its `cell_in` slice is 0.
- R3: The schedule for cell 0 runs in frames of 2(N²−1) cycles. Each frame is N+1 passes of 2(N−1) cycles each. Cell 0's select bit is 1 throughout pass 0 and 0 in every later pass. Frames repeat back to back.
- R4: Cell 0's clear bit is 1 on the first cycle of every pass and 0 on every other cycle.
- R5: Cell 0's mode bit (1 = triangulate, 0 = annul) is 1 for the first N−1 cycles of each pass and 0 for the remaining N−1 cycles.
- R6: For every k ≥ 1, cell k's mode, clear and select bits equal cell k−1's bits one clock edge earlier.
- R7: A clock edge that samples `restart` high returns the schedule to cycle 0 of a frame. Cell 0 then shows mode, clear and select all 1.
- R8: While `rst_n` is low, cell 0 shows cycle 0 of the schedule, every other cell's control bits are 0, and every register column holds 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| restart | input | 1 | Synchronous return of the schedule to frame cycle 0 |
| mat_in | input | 2N·W | Fresh matrix operands, slice k for cell k |
| cell_res | input | (2N−1)·W | Cell results, slice j from cell j, entering column j |
| cell_in | output | 2N·W | Selected operand presented to each cell, slice k for cell k |
| cell_mode | output | 2N | Per-cell operation mode, 1 triangulate, 0 annul |
| cell_clear | output | 2N | Per-cell clear of internal state, active high |
| cell_sel | output | 2N | Per-cell operand source, 1 fresh data, 0 feedback |

## Verification
The bench builds the block three times, with N = 2, 3 and 4, giving rows of 4, 6 and 8 cells and column depths of 2, 4 and 6. Every cell's control waveform is compared on every cycle against a schedule worked out from frame and pass arithmetic. The run covers several full frames, the wrap from one frame into the next, and a restart in mid-pass. The feedback operands carry a value that is unique to each column and cycle, so a column that is one register too short or too long, or that is routed to the wrong neighbour, shows up as a data mismatch.

// File: rtl/sysrow_pkg.sv
package sysrow_pkg;
  // Control bundle handed to one cell
  typedef struct packed {
    logic mode;   // 1 triangulate, 0 annul
    logic clear;  // clear cell state
    logic sel;    // 1 fresh operand, 0 feedback operand
  } ctl_t;
endpackage

// File: rtl/sysrow_ctrl.sv
module sysrow_ctrl
  import sysrow_pkg::*;
#(
  parameter int N = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output ctl_t base
);
  localparam int STEPS  = 2 * (N - 1);
  localparam int PASSES = N + 1;
  localparam int SW     = (STEPS  > 1) ? $clog2(STEPS)  : 1;
  localparam int PW     = (PASSES > 1) ? $clog2(PASSES) : 1;

  logic [SW-1:0] step_q, step_d;
  logic [PW-1:0] pass_q, pass_d;
  logic          last_step, last_pass;

  assign last_step = (step_q == SW'(STEPS - 1));
  assign last_pass = (pass_q == PW'(PASSES - 1));

  always_comb begin
    step_d = step_q;
    pass_d = pass_q;
    if (restart) begin
      step_d = '0;
      pass_d = '0;
    end else if (last_step) begin
      step_d = '0;
      pass_d = last_pass ? '0 : pass_q + PW'(1);
    end else begin
      step_d = step_q + SW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q <= '0;
      pass_q <= '0;
    end else begin
      step_q <= step_d;
      pass_q <= pass_d;
    end
  end

  always_comb begin
    base.clear = (step_q == '0);
    base.mode  = (step_q < SW'(N - 1));
    base.sel   = (pass_q == '0);
  end
endmodule

// File: rtl/sysrow_skew.sv
module sysrow_skew
  import sysrow_pkg::*;
#(
  parameter int NC = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  ctl_t          base,
  output logic [NC-1:0] mode,
  output logic [NC-1:0] clear,
  output logic [NC-1:0] sel
);
  ctl_t stage [NC];

  for (genvar k = 0; k < NC; k++) begin : g_tap
    if (k == 0) begin : g_head
      assign stage[0] = base;
    end else begin : g_dly
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage[k] <= '0;
        else        stage[k] <= stage[k-1];
      end
    end
    assign mode[k]  = stage[k].mode;
    assign clear[k] = stage[k].clear;
    assign sel[k]   = stage[k].sel;
  end
endmodule

// File: rtl/sysrow_column.sv
module sysrow_column #(
  parameter int W     = 16,
  parameter int DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] r [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) r[i] <= '0;
    end else begin
      r[0] <= din;
      for (int i = 1; i < DEPTH; i++) r[i] <= r[i-1];
    end
  end

  assign dout = r[DEPTH-1];
endmodule

// File: rtl/sysrow_seq.sv
module sysrow_seq
  import sysrow_pkg::*;
#(
  parameter int N = 2,
  parameter int W = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      restart,
  input  logic [2*N*W-1:0]          mat_in,
  input  logic [(2*N-1)*W-1:0]      cell_res,
  output logic [2*N*W-1:0]          cell_in,
  output logic [2*N-1:0]            cell_mode,
  output logic [2*N-1:0]            cell_clear,
  output logic [2*N-1:0]            cell_sel
);
  localparam int NC    = 2 * N;
  localparam int NCOL  = NC - 1;
  localparam int DEPTH = 2 * (N - 1);

  ctl_t         base;
  logic [W-1:0] fb [NC];

  sysrow_ctrl #(.N(N)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (restart),
    .base    (base)
  );

  sysrow_skew #(.NC(NC)) u_skew (
    .clk   (clk),
    .rst_n (rst_n),
    .base  (base),
    .mode  (cell_mode),
    .clear (cell_clear),
    .sel   (cell_sel)
  );

  assign fb[0] = '0;

  for (genvar j = 0; j < NCOL; j++) begin : g_col
    sysrow_column #(.W(W), .DEPTH(DEPTH)) u_col (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (cell_res[j*W +: W]),
      .dout  (fb[j+1])
    );
  end

  for (genvar k = 0; k < NC; k++) begin : g_mux
    assign cell_in[k*W +: W] = cell_sel[k] ? mat_in[k*W +: W] : fb[k];
  end
endmodule

// File: rtl/sysrow_seq_chk.sv
module sysrow_seq_chk #(
  parameter int N = 2,
  parameter int W = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               restart,
  input logic [2*N*W-1:0]   mat_in,
  input logic [2*N*W-1:0]   cell_in,
  input logic [2*N-1:0]     cell_mode,
  input logic [2*N-1:0]     cell_clear,
  input logic [2*N-1:0]     cell_sel
);
  localparam int NC = 2 * N;

  logic armed;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  for (genvar k = 1; k < NC; k++) begin : g_stag
    p_stagger_mode_r6: assert property (@(posedge clk) disable iff (!rst_n)
      armed |-> cell_mode[k] == $past(cell_mode[k-1]));
    p_stagger_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
      armed |-> cell_clear[k] == $past(cell_clear[k-1]));
    p_stagger_sel_r6: assert property (@(posedge clk) disable iff (!rst_n)
      armed |-> cell_sel[k] == $past(cell_sel[k-1]));
  end

  for (genvar k = 0; k < NC; k++) begin : g_fresh
    p_fresh_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
      cell_sel[k] |-> cell_in[k*W +: W] == mat_in[k*W +: W]);
  end

  p_clear_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cell_clear[0] && !restart) |=> !cell_clear[0]);

  p_mode_at_pass_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cell_clear[0] |-> cell_mode[0]);

  p_sel_drop_at_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cell_sel[0]) |-> cell_clear[0]);

  p_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cell_clear[0] && cell_sel[0] && cell_mode[0]));
endmodule

bind sysrow_seq sysrow_seq_chk #(.N(N), .W(W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .restart    (restart),
  .mat_in     (mat_in),
  .cell_in    (cell_in),
  .cell_mode  (cell_mode),
  .cell_clear (cell_clear),
  .cell_sel   (cell_sel)
);

// File: tb/tb_sysrow_seq.sv
module row_sweep #(
  parameter int N = 2,
  parameter int RUN = 150,
  parameter int RESTART_AT = 40
) (
  input  logic clk,
  input  logic rst_n,
  output int   compared,
  output int   mism,
  output logic done
);
  localparam int W  = 16;
  localparam int NC = 2 * N;
  localparam int D  = 2 * (N - 1);
  localparam int T  = 2 * (N * N - 1);

  logic                 restart;
  logic [NC*W-1:0]      mat_in;
  logic [(NC-1)*W-1:0]  cell_res;
  logic [NC*W-1:0]      cell_in;
  logic [NC-1:0]        cell_mode, cell_clear, cell_sel;

  sysrow_seq #(.N(N), .W(W)) dut (
    .clk(clk), .rst_n(rst_n), .restart(restart),
    .mat_in(mat_in), .cell_res(cell_res), .cell_in(cell_in),
    .cell_mode(cell_mode), .cell_clear(cell_clear), .cell_sel(cell_sel)
  );

  int cyc, cnt_m;
  bit hm [NC];
  bit hc [NC];
  bit hs [NC];

  function automatic logic [W-1:0] res_val(int j, int c);
    return W'(j * 1000 + c * 7 + 1);
  endfunction

  function automatic logic [W-1:0] mat_val(int k, int c);
    return W'(16'h8000 | (k * 256 + c));
  endfunction

  task automatic base_of(input int c, output bit m, output bit cl, output bit s);
    m  = (c % D) < (N - 1);
    cl = (c % D) == 0;
    s  = (c / D) == 0;
  endtask

  task automatic chk(input string req, input int k, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mism++;
      $display("FAIL %s N=%0d cell %0d cyc %0d actual %0h expected %0h",
               req, N, k, cyc, act, exp);
    end
  endtask

  task automatic drive();
    for (int j = 0; j < NC - 1; j++) cell_res[j*W +: W] = res_val(j, cyc);
    for (int k = 0; k < NC; k++) mat_in[k*W +: W] = mat_val(k, cyc);
  endtask

  task automatic check_all();
    int exp_d;
    for (int k = 0; k < NC; k++) begin
      if (k == 0) begin
        chk("R5 mode", k, int'(cell_mode[k]), int'(hm[k]));
        chk("R4 clear", k, int'(cell_clear[k]), int'(hc[k]));
        chk("R3 sel", k, int'(cell_sel[k]), int'(hs[k]));
      end else begin
        chk("R6 mode skew", k, int'(cell_mode[k]), int'(hm[k]));
        chk("R6 clear skew", k, int'(cell_clear[k]), int'(hc[k]));
        chk("R6 sel skew", k, int'(cell_sel[k]), int'(hs[k]));
      end
      if (hs[k]) begin
        chk("R2 fresh operand", k, int'(cell_in[k*W +: W]), int'(mat_val(k, cyc)));
      end else begin
        if (k == 0) exp_d = 0;
        else if (cyc >= D) exp_d = int'(res_val(k - 1, cyc - D));
        else exp_d = 0;
        chk(k == 0 ? "R2 boundary feedback" : "R1 feedback operand",
            k, int'(cell_in[k*W +: W]), exp_d);
      end
    end
  endtask

  task automatic step_model();
    bit m, cl, s;
    for (int k = NC - 1; k > 0; k--) begin
      hm[k] = hm[k-1]; hc[k] = hc[k-1]; hs[k] = hs[k-1];
    end
    if (restart) cnt_m = 0;          // R7 restart returns to frame cycle 0
    else cnt_m = (cnt_m + 1) % T;    // R3 frame of 2(N*N-1) cycles
    base_of(cnt_m, m, cl, s);
    hm[0] = m; hc[0] = cl; hs[0] = s;
  endtask

  initial begin
    bit m, cl, s;
    compared = 0; mism = 0; done = 1'b0;
    cyc = 0; cnt_m = 0; restart = 1'b0;
    for (int k = 0; k < NC; k++) begin hm[k] = 0; hc[k] = 0; hs[k] = 0; end
    base_of(0, m, cl, s);
    hm[0] = m; hc[0] = cl; hs[0] = s;
    drive();
    // R8 reset state
    repeat (3) @(negedge clk);
    check_all();
    @(posedge rst_n);
    for (int i = 0; i < RUN; i++) begin
      @(posedge clk);
      cyc++;
      step_model();
      #1;
      drive();
      restart = (cyc == RESTART_AT);
      @(negedge clk);
      check_all();
    end
    done = 1'b1;
  end
endmodule

module tb_sysrow_seq;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 5000;

  logic clk, rst_n;
  int   c2, m2, c3, m3, c4, m4;
  logic d2, d3, d4;

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  row_sweep #(.N(2), .RESTART_AT(17)) u_n2 (.clk(clk), .rst_n(rst_n), .compared(c2), .mism(m2), .done(d2));
  row_sweep #(.N(3), .RESTART_AT(29)) u_n3 (.clk(clk), .rst_n(rst_n), .compared(c3), .mism(m3), .done(d3));
  row_sweep #(.N(4), .RESTART_AT(40)) u_n4 (.clk(clk), .rst_n(rst_n), .compared(c4), .mism(m4), .done(d4));

  initial begin
    int total, bad, waited;
    rst_n = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    waited = 0;
    bad = 0;
    while (!(d2 && d3 && d4) && waited < WATCHDOG) begin
      @(negedge clk);
      waited++;
    end
    total = c2 + c3 + c4;
    bad   = m2 + m3 + m4;
    if (!(d2 && d3 && d4)) begin
      total++;
      bad++;
      $display("FAIL watchdog expired, R3 schedule run incomplete actual %0d expected done", waited);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", total, bad);
    $finish;
  end
endmodule